// File: doc/BRIEF.md
# Write-Invalidate Snooping Coherence Controller

This block is the coherence controller for one private cache in a bus-based symmetric multiprocessor. It tracks a small direct-mapped set of block tags, and each block is in one of three states: Invalid, Shared or Exclusive. It serves processor reads and writes locally when the block state permits. When it does not, it requests the single shared bus and issues a read miss, a write miss or a writeback. Because only one transaction occupies the bus at a time, the order of bus grants is the global order of writes to any address.

At the same time the controller watches every transaction that the other caches place on the bus. A snooped read miss to a block it holds Exclusive makes it supply the block and drop to Shared. A snooped write miss to a block it holds removes the copy, and the block is supplied first if it was Exclusive. Snoop lookups are processed every cycle and win the tag array over a processor lookup in the same cycle. Block data, memory and the arbiter sit outside the block. The address is a block address: its low `IDX_W` bits select the set and the remaining bits form the tag.

Top module: `snp_coh_ctrl`

## Requirements
- R1: After reset every set is Invalid, `cpu_ready`, `bus_req` and `snp_flush` are low, and the first access to any address goes to the bus.
- R2: A processor read whose tag matches a Shared or Exclusive set completes with `cpu_ready` high in the same cycle as `cpu_valid`, and no bus transaction is requested.
- R3: A processor read that does not find its tag in a valid set issues one read miss (`bus_cmd` = 1) at the request address, and the set then holds the block as Shared.
- R4: A processor write that hits an Exclusive set completes in the same cycle as `cpu_valid` with no bus transaction.
- R5: A processor write that hits a Shared set issues one full write miss (`bus_cmd` = 2), and the set becomes Exclusive.
- R6: A processor write that does not find its tag in a valid set issues one write miss, and the set then holds the block as Exclusive.
- R7: When a read or write misses on a set whose resident block is Exclusive under another tag, a writeback (`bus_cmd` = 3) at the resident block's address is granted first, and the miss for the new address follows it.
- R8: A snooped read miss (`snp_cmd` = 1) to a block held Exclusive raises `snp_flush` in that cycle and leaves the block Shared; for a block held Shared it raises no flush and the block stays Shared.
- R9: A snooped write miss (`snp_cmd` = 2) to a held block invalidates it; `snp_flush` is raised in that cycle only if the block was Exclusive.
- R10: Snooped writebacks (`snp_cmd` = 3), and snoops whose tag does not match the resident block, raise no flush and change no state.
- R11: In a cycle with `snp_valid` high, `cpu_ready` stays low, and the processor lookup is retried in the next cycle.
- R12: `bus_req`, `bus_cmd` and `bus_addr` are held until `bus_gnt`. The transaction is complete in the grant cycle, and `cpu_ready` rises in the grant cycle of the request's last transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present; held with its fields until `cpu_ready` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address of the request |
| cpu_ready | output | 1 | Request accepted and completed in this cycle |
| bus_req | output | 1 | Bus ownership wanted for the transaction on `bus_cmd` |
| bus_cmd | output | 2 | 0 idle, 1 read miss, 2 write miss, 3 writeback |
| bus_addr | output | ADDR_W | Block address of the bus transaction |
| bus_gnt | input | 1 | Bus granted; the transaction is performed in this cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_flush | output | 1 | This cache supplies its Exclusive copy for the snooped transaction |

## Verification
Hits are due in the same cycle as the request, so the bench samples `cpu_ready` at the falling edge of the cycle in which `cpu_valid` is raised. A miss spends one cycle on the lookup and then one grant per transaction. With the arbiter always granting, the bench counts cycles from the request and expects `cpu_ready` at cycle index 0, 1 or 2 for zero, one or two transactions. `snp_flush` is combinational on the snoop, so the bench samples it at the falling edge of the other cache's grant cycle. State changes made at a grant edge are judged by how the next access behaves on the bus. With random grant delays the bench checks the command sequence and the flush count rather than the latency, and it checks that the request fields hold steady while a request waits for its grant.

// File: rtl/snp_coh_pkg.sv
`timescale 1ns/1ps
package snp_coh_pkg;

   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHD = 2'd1,
      LS_EXC = 2'd2
   } line_st_e;

   typedef enum logic [1:0] {
      BC_IDLE   = 2'd0,
      BC_RDMISS = 2'd1,
      BC_WRMISS = 2'd2,
      BC_WBACK  = 2'd3
   } bus_cmd_e;

endpackage

// File: rtl/snp_line_store.sv
`timescale 1ns/1ps
module snp_line_store
   import snp_coh_pkg::*;
#(
   parameter int IDX_W = 2,
   parameter int TAG_W = 10
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [IDX_W-1:0]            lk_a_idx,
   output logic [TAG_W-1:0]            lk_a_tag,
   output line_st_e                    lk_a_st,
   input  logic [IDX_W-1:0]            lk_b_idx,
   output logic [TAG_W-1:0]            lk_b_tag,
   output line_st_e                    lk_b_st,
   input  logic                        sw_en,
   input  logic [IDX_W-1:0]            sw_idx,
   input  line_st_e                    sw_st,
   input  logic                        fw_en,
   input  logic [IDX_W-1:0]            fw_idx,
   input  logic [TAG_W-1:0]            fw_tag,
   input  line_st_e                    fw_st,
   output logic [(1<<IDX_W)-1:0][1:0]  st_all
);

   localparam int SETS = 1 << IDX_W;

   if (SETS > 4096) begin : g_bad_sets
      $error("snp_line_store: too many sets for a flop-based tag store");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("snp_line_store: tag width must be positive");
   end

   logic [SETS-1:0][TAG_W-1:0] tag_all;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic [1:0]       st_q;
      logic [TAG_W-1:0] tag_q;

      // a fill comes from the bus owner; a snoop comes from another owner,
      // so both in one cycle is not expected; the fill is the later event
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= LS_INV;
            tag_q <= '0;
         end else if (fw_en && fw_idx == IDX_W'(s)) begin
            st_q  <= fw_st;
            tag_q <= fw_tag;
         end else if (sw_en && sw_idx == IDX_W'(s)) begin
            st_q  <= sw_st;
         end
      end

      assign st_all[s]  = st_q;
      assign tag_all[s] = tag_q;
   end

   assign lk_a_tag = tag_all[lk_a_idx];
   assign lk_a_st  = line_st_e'(st_all[lk_a_idx]);
   assign lk_b_tag = tag_all[lk_b_idx];
   assign lk_b_st  = line_st_e'(st_all[lk_b_idx]);

   // R1
   reset_all_invalid_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> st_all == '0);

endmodule

// File: rtl/snp_snoop_unit.sv
`timescale 1ns/1ps
module snp_snoop_unit
   import snp_coh_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 2
) (
   input  logic                      snp_valid,
   input  logic [1:0]                snp_cmd,
   input  logic [ADDR_W-1:0]         snp_addr,
   output logic [IDX_W-1:0]          lk_idx,
   input  logic [ADDR_W-IDX_W-1:0]   lk_tag,
   input  line_st_e                  lk_st,
   output logic                      sw_en,
   output logic [IDX_W-1:0]          sw_idx,
   output line_st_e                  sw_st,
   output logic                      snp_hit,
   output logic                      snp_flush
);

   assign lk_idx  = snp_addr[IDX_W-1:0];
   assign sw_idx  = snp_addr[IDX_W-1:0];
   assign snp_hit = snp_valid && lk_st != LS_INV
                    && lk_tag == snp_addr[ADDR_W-1:IDX_W];

   always_comb begin
      sw_en     = 1'b0;
      sw_st     = lk_st;
      snp_flush = 1'b0;
      if (snp_hit) begin
         unique case (bus_cmd_e'(snp_cmd))
            BC_RDMISS: begin
               if (lk_st == LS_EXC) begin
                  snp_flush = 1'b1;
                  sw_en     = 1'b1;
                  sw_st     = LS_SHD;
               end
            end
            BC_WRMISS: begin
               snp_flush = (lk_st == LS_EXC);
               sw_en     = 1'b1;
               sw_st     = LS_INV;
            end
            default: begin
               sw_en = 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/snp_req_fsm.sv
`timescale 1ns/1ps
module snp_req_fsm
   import snp_coh_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cpu_valid,
   input  logic                      cpu_write,
   input  logic [ADDR_W-1:0]         cpu_addr,
   output logic                      cpu_ready,
   input  logic                      snp_valid,
   output logic [IDX_W-1:0]          look_idx,
   input  logic [ADDR_W-IDX_W-1:0]   look_tag,
   input  line_st_e                  look_st,
   output logic                      bus_req,
   output bus_cmd_e                  bus_cmd,
   output logic [ADDR_W-1:0]         bus_addr,
   input  logic                      bus_gnt,
   output logic                      fill_en,
   output logic [IDX_W-1:0]          fill_idx,
   output logic [ADDR_W-IDX_W-1:0]   fill_tag,
   output line_st_e                  fill_st
);

   localparam int TAG_W = ADDR_W - IDX_W;

   typedef enum logic [1:0] {F_IDLE, F_WBACK, F_MISS} fsm_e;

   fsm_e             fs_q, fs_d;
   logic [ADDR_W-1:0] rq_addr_q;
   logic             rq_wr_q;
   logic [TAG_W-1:0] vic_tag_q;
   logic             cap;
   logic             resident;

   logic [IDX_W-1:0] in_idx, rq_idx;
   logic [TAG_W-1:0] in_tag, rq_tag;

   assign in_idx   = cpu_addr[IDX_W-1:0];
   assign in_tag   = cpu_addr[ADDR_W-1:IDX_W];
   assign rq_idx   = rq_addr_q[IDX_W-1:0];
   assign rq_tag   = rq_addr_q[ADDR_W-1:IDX_W];
   assign look_idx = (fs_q == F_IDLE) ? in_idx : rq_idx;
   assign resident = look_st != LS_INV && look_tag == in_tag;

   always_comb begin
      fs_d      = fs_q;
      cpu_ready = 1'b0;
      bus_req   = 1'b0;
      bus_cmd   = BC_IDLE;
      bus_addr  = rq_addr_q;
      fill_en   = 1'b0;
      fill_idx  = rq_idx;
      fill_tag  = rq_tag;
      fill_st   = LS_INV;
      cap       = 1'b0;
      unique case (fs_q)
         F_IDLE: begin
            if (cpu_valid && !snp_valid) begin
               if (resident && (!cpu_write || look_st == LS_EXC)) begin
                  cpu_ready = 1'b1;
               end else begin
                  cap  = 1'b1;
                  fs_d = (!resident && look_st == LS_EXC) ? F_WBACK : F_MISS;
               end
            end
         end
         F_WBACK: begin
            if (look_st == LS_EXC && look_tag == vic_tag_q) begin
               bus_req  = 1'b1;
               bus_cmd  = BC_WBACK;
               bus_addr = {vic_tag_q, rq_idx};
               if (bus_gnt) begin
                  fill_en  = 1'b1;
                  fill_tag = vic_tag_q;
                  fill_st  = LS_INV;
                  fs_d     = F_MISS;
               end
            end else begin
               fs_d = F_MISS;
            end
         end
         F_MISS: begin
            bus_req = 1'b1;
            bus_cmd = rq_wr_q ? BC_WRMISS : BC_RDMISS;
            if (bus_gnt) begin
               fill_en   = 1'b1;
               fill_st   = rq_wr_q ? LS_EXC : LS_SHD;
               cpu_ready = 1'b1;
               fs_d      = F_IDLE;
            end
         end
         default: fs_d = F_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q      <= F_IDLE;
         rq_addr_q <= '0;
         rq_wr_q   <= 1'b0;
         vic_tag_q <= '0;
      end else begin
         fs_q <= fs_d;
         if (cap) begin
            rq_addr_q <= cpu_addr;
            rq_wr_q   <= cpu_write;
            vic_tag_q <= look_tag;
         end
      end
   end

   // R7
   wb_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_gnt && bus_cmd == BC_WBACK
      |=> bus_req && (bus_cmd == BC_RDMISS || bus_cmd == BC_WRMISS));

endmodule

// File: rtl/snp_coh_ctrl.sv
`timescale 1ns/1ps
module snp_coh_ctrl
   import snp_coh_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_ready,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_gnt,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_flush
);

   localparam int TAG_W = ADDR_W - IDX_W;
   localparam int SETS  = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
      $error("snp_coh_ctrl: IDX_W must leave at least one tag bit");
   end

   logic [IDX_W-1:0]      a_idx, b_idx, sw_idx, fw_idx;
   logic [TAG_W-1:0]      a_tag, b_tag, fw_tag;
   line_st_e              a_st, b_st, sw_st, fw_st;
   logic                  sw_en, fw_en, snp_hit;
   bus_cmd_e              cmd_w;
   logic [SETS-1:0][1:0]  st_all;

   snp_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_a_idx (a_idx),
      .lk_a_tag (a_tag),
      .lk_a_st  (a_st),
      .lk_b_idx (b_idx),
      .lk_b_tag (b_tag),
      .lk_b_st  (b_st),
      .sw_en    (sw_en),
      .sw_idx   (sw_idx),
      .sw_st    (sw_st),
      .fw_en    (fw_en),
      .fw_idx   (fw_idx),
      .fw_tag   (fw_tag),
      .fw_st    (fw_st),
      .st_all   (st_all)
   );

   snp_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snoop (
      .snp_valid (snp_valid),
      .snp_cmd   (snp_cmd),
      .snp_addr  (snp_addr),
      .lk_idx    (b_idx),
      .lk_tag    (b_tag),
      .lk_st     (b_st),
      .sw_en     (sw_en),
      .sw_idx    (sw_idx),
      .sw_st     (sw_st),
      .snp_hit   (snp_hit),
      .snp_flush (snp_flush)
   );

   snp_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_valid (cpu_valid),
      .cpu_write (cpu_write),
      .cpu_addr  (cpu_addr),
      .cpu_ready (cpu_ready),
      .snp_valid (snp_valid),
      .look_idx  (a_idx),
      .look_tag  (a_tag),
      .look_st   (a_st),
      .bus_req   (bus_req),
      .bus_cmd   (cmd_w),
      .bus_addr  (bus_addr),
      .bus_gnt   (bus_gnt),
      .fill_en   (fw_en),
      .fill_idx  (fw_idx),
      .fill_tag  (fw_tag),
      .fill_st   (fw_st)
   );

   assign bus_cmd = cmd_w;

   logic [IDX_W-1:0] chk_cidx_q, chk_sidx_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_cidx_q <= '0;
         chk_sidx_q <= '0;
      end else begin
         chk_cidx_q <= cpu_addr[IDX_W-1:0];
         chk_sidx_q <= snp_addr[IDX_W-1:0];
      end
   end

   // R3
   rd_done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid && cpu_ready && !cpu_write |=> st_all[chk_cidx_q] != 2'(LS_INV));

   // R6
   wr_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid && cpu_ready && cpu_write |=> st_all[chk_cidx_q] == 2'(LS_EXC));

   // R8
   snp_rd_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_hit && snp_cmd == 2'(BC_RDMISS) && b_st == LS_EXC && !bus_gnt
      |-> snp_flush ##1 st_all[chk_sidx_q] == 2'(LS_SHD));

   // R9
   snp_wr_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_hit && snp_cmd == 2'(BC_WRMISS) && !bus_gnt
      |=> st_all[chk_sidx_q] == 2'(LS_INV));

   // R11
   snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !cpu_ready);

   // R12
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_gnt && !snp_valid
      |=> bus_req && $stable(bus_cmd) && $stable(bus_addr));

   // R12
   gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_gnt |-> bus_req && !snp_valid);

endmodule

// File: tb/test_snp_coh_ctrl.sv
`timescale 1ns/1ps
module test_snp_coh_ctrl;

   localparam int AW = 12;
   localparam int NC = 3;
   localparam logic [AW-1:0] AX = 12'h010;
   localparam logic [AW-1:0] AY = 12'h020;
   localparam logic [AW-1:0] AZ = 12'h011;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n;
   logic          cpu_v [NC];
   logic          cpu_w [NC];
   logic [AW-1:0] cpu_a [NC];
   logic          rdy   [NC];
   logic          breq  [NC];
   logic          gnt   [NC];
   logic          sv    [NC];
   logic          fl    [NC];
   logic [1:0]    bcmd  [NC];
   logic [1:0]    scmd  [NC];
   logic [AW-1:0] baddr [NC];
   logic [AW-1:0] saddr [NC];
   logic          gnt_en, inj_v, rnd_gnt;
   logic [1:0]    inj_cmd;
   logic [AW-1:0] inj_a;

   int n_chk = 0;
   int n_err = 0;
   bit fin = 0;

   int            m_st  [NC][4];
   logic [AW-3:0] m_tag [NC][4];

   for (genvar c = 0; c < NC; c++) begin : g_c
      snp_coh_ctrl #(.ADDR_W(AW), .IDX_W(2)) i_snp_coh_ctrl (
         .clk       (clk),
         .rst_n     (rst_n),
         .cpu_valid (cpu_v[c]),
         .cpu_write (cpu_w[c]),
         .cpu_addr  (cpu_a[c]),
         .cpu_ready (rdy[c]),
         .bus_req   (breq[c]),
         .bus_cmd   (bcmd[c]),
         .bus_addr  (baddr[c]),
         .bus_gnt   (gnt[c]),
         .snp_valid (sv[c]),
         .snp_cmd   (scmd[c]),
         .snp_addr  (saddr[c]),
         .snp_flush (fl[c])
      );
   end

   always_comb begin
      logic taken;
      taken = 1'b0;
      for (int c = 0; c < NC; c++) begin
         gnt[c] = 1'b0;
         if (gnt_en && breq[c] && !taken) begin
            gnt[c] = 1'b1;
            taken  = 1'b1;
         end
      end
      for (int c = 0; c < NC; c++) begin
         sv[c] = 1'b0; scmd[c] = 2'd0; saddr[c] = '0;
         for (int o = 0; o < NC; o++) begin
            if (o != c && gnt[o]) begin
               sv[c] = 1'b1; scmd[c] = bcmd[o]; saddr[c] = baddr[o];
            end
         end
         if (c == 0 && inj_v) begin
            sv[c] = 1'b1; scmd[c] = inj_cmd; saddr[c] = inj_a;
         end
      end
   end

   task automatic chk(input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic access(input int c, input bit wr, input logic [AW-1:0] a,
                         input bit lat, input string tag_rq);
      int idx, st, e_cmd, e_ntx, e_fl, n_tx, n_fl, cyc;
      bit res, e_wb, done, p_wait;
      logic [AW-1:0] e_vaddr, p_addr;
      logic [1:0] p_cmd;
      int tx_cmd [2];
      logic [AW-1:0] tx_addr [2];
      string rq;
      idx = int'(a[1:0]);
      st  = m_st[c][idx];
      res = m_tag[c][idx] == a[AW-1:2] && st != 0;
      e_wb = !res && st == 2;
      e_vaddr = {m_tag[c][idx], a[1:0]};
      if (res) e_cmd = (wr && st == 1) ? 2 : 0;
      else     e_cmd = wr ? 2 : 1;
      e_ntx = (e_cmd != 0 ? 1 : 0) + (e_wb ? 1 : 0);
      e_fl = 0;
      for (int o = 0; o < NC; o++)
         if (o != c && e_cmd != 0 && m_tag[o][idx] == a[AW-1:2] && m_st[o][idx] == 2) e_fl++;
      if (e_wb) rq = "R7";
      else if (res && !wr) rq = "R2";
      else if (res && st == 2) rq = "R4";
      else if (res) rq = "R5";
      else if (wr) rq = "R6";
      else rq = "R3";
      if (tag_rq != "") rq = tag_rq;
      tx_cmd[0] = 0; tx_cmd[1] = 0; tx_addr[0] = '0; tx_addr[1] = '0;
      n_tx = 0; n_fl = 0; cyc = 0; done = 0; p_wait = 0; p_cmd = 0; p_addr = '0;
      cpu_v[c] = 1'b1; cpu_w[c] = wr; cpu_a[c] = a;
      while (!done) begin
         @(negedge clk);
         if (p_wait && breq[c]) begin
            // R12: held request fields
            chk("R12", int'({p_cmd, p_addr}), int'({bcmd[c], baddr[c]}));
         end
         p_wait = breq[c] && !gnt[c];
         p_cmd = bcmd[c]; p_addr = baddr[c];
         if (gnt[c]) begin
            if (n_tx < 2) begin
               tx_cmd[n_tx] = int'(bcmd[c]);
               tx_addr[n_tx] = baddr[c];
            end
            n_tx++;
         end
         for (int o = 0; o < NC; o++) if (o != c && fl[o]) n_fl++;
         if (rdy[c]) done = 1;
         else cyc++;
         @(posedge clk); #1;
         if (done) cpu_v[c] = 1'b0;
         if (rnd_gnt) gnt_en = ($urandom % 3) != 0;
      end
      chk(rq, n_tx, e_ntx);
      if (e_wb) begin
         chk("R7", int'(tx_cmd[0]), 3);
         chk("R7", int'(tx_addr[0]), int'(e_vaddr));
         chk(rq, tx_cmd[1], e_cmd);
         chk(rq, int'(tx_addr[1]), int'(a));
      end else if (e_cmd != 0) begin
         chk(rq, tx_cmd[0], e_cmd);
         chk(rq, int'(tx_addr[0]), int'(a));
      end
      chk(e_cmd == 1 ? "R8" : "R9", n_fl, e_fl);
      if (lat) chk("R12", cyc, e_ntx);
      if (e_cmd != 0) begin
         for (int o = 0; o < NC; o++) begin
            if (o != c && m_tag[o][idx] == a[AW-1:2] && m_st[o][idx] != 0)
               m_st[o][idx] = (e_cmd == 1) ? 1 : 0;
         end
         m_tag[c][idx] = a[AW-1:2];
         m_st[c][idx] = wr ? 2 : 1;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!fin) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1213));
      rst_n = 1'b0; gnt_en = 1'b1; rnd_gnt = 1'b0;
      inj_v = 1'b0; inj_cmd = 2'd0; inj_a = '0;
      for (int c = 0; c < NC; c++) begin
         cpu_v[c] = 1'b0; cpu_w[c] = 1'b0; cpu_a[c] = '0;
         for (int s = 0; s < 4; s++) begin m_st[c][s] = 0; m_tag[c][s] = '0; end
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin
         chk("R1", int'(rdy[c]), 0);
         chk("R1", int'(breq[c]), 0);
         chk("R1", int'(fl[c]), 0);
      end
      @(posedge clk); #1;

      // directed replay across three caches and two conflicting addresses
      access(0, 0, AX, 1, "R1");
      access(1, 0, AX, 1, "");
      access(2, 0, AX, 1, "");
      access(0, 1, AX, 1, "");
      access(2, 1, AX, 1, "");
      access(1, 0, AX, 1, "");
      access(0, 0, AX, 1, "");
      access(0, 0, AY, 1, "");
      access(1, 1, AX, 1, "");
      access(1, 0, AY, 1, "");
      access(1, 1, AX, 1, "");
      access(1, 1, AY, 1, "");
      access(0, 0, AY, 1, "");
      access(0, 1, AZ, 1, "");
      access(0, 1, AZ, 1, "");

      // R10: snooped writeback and non-matching snoop leave cache 0 intact
      access(0, 1, AX, 1, "");
      inj_v = 1'b1; inj_cmd = 2'd3; inj_a = AX;
      @(negedge clk);
      chk("R10", int'(fl[0]), 0);
      @(posedge clk); #1;
      inj_cmd = 2'd2; inj_a = 12'h030;
      @(negedge clk);
      chk("R10", int'(fl[0]), 0);
      @(posedge clk); #1;
      inj_v = 1'b0;
      access(0, 1, AX, 1, "R10");

      // R11: snoop in the request cycle defers a hit by one cycle
      cpu_v[0] = 1'b1; cpu_w[0] = 1'b0; cpu_a[0] = AX;
      inj_v = 1'b1; inj_cmd = 2'd1; inj_a = 12'h031;
      @(negedge clk);
      chk("R11", int'(rdy[0]), 0);
      @(posedge clk); #1;
      inj_v = 1'b0;
      @(negedge clk);
      chk("R11", int'(rdy[0]), 1);
      chk("R11", int'(breq[0]), 0);
      @(posedge clk); #1;
      cpu_v[0] = 1'b0;

      // constrained random with grant delays
      rnd_gnt = 1'b1;
      for (int k = 0; k < 200; k++) begin
         int c, sel;
         logic [AW-1:0] a;
         c = int'($urandom % NC);
         sel = int'($urandom % 3);
         a = (sel == 0) ? AX : (sel == 1) ? AY : AZ;
         access(c, 1'($urandom % 2), a, 0, "");
      end
      rnd_gnt = 1'b0; gnt_en = 1'b1;

      fin = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule